// File: doc/BRIEF.md
# Configurable Minimum/Maximum Selector

This unit picks the smaller or the larger of two XLEN-bit operands. A three-bit mode field sets how the two operands are compared. One mode bit limits the comparison to the lower half of each operand. A second bit makes the comparison signed. The third bit selects the maximum instead of the minimum. Every mode uses the same unsigned comparator. For half-width mode, the operands are prepared by moving their lower halves to the top and filling the low bits with zero. For signed mode, the sign bit is flipped. For maximum mode, the two prepared operands are exchanged. The value returned is always the complete, unmodified source operand that was chosen.

The first operand may be marked as the zero register. In that case it takes part in the operation as the value zero. When the record flag is set, the unit also writes a four-bit condition field. The field holds a one-hot less/greater/equal code that describes the original operands in the selected comparison domain. The incoming summary-overflow bit is placed in the least significant position. The result, the condition field and the write strobe are registered and appear one cycle after an operation is accepted.

Top module: `minmax_unit`

## Requirements
- R1: While reset is active and after it is released, before any operation, out_valid, cr_we, result and cr_out are all zero.
- R2: An operation accepted with in_valid high gives out_valid high on the next clock edge. out_valid is low in every other cycle.
- R3: With mode = 3'b000 the result is the operand with the smaller unsigned full-width value.
- R4: Mode bit 2 set selects the operand with the larger value under the comparison chosen by bits 1 and 0.
- R5: Mode bit 1 set compares the operands as two's-complement signed numbers.
- R6: Mode bit 0 set compares only the lower XLEN/2 bits of each operand. The full XLEN-bit chosen operand is still returned.
- R7: When a_is_zero_reg is high, operand A is taken as zero for both the comparison and the result.
- R8: When the compared values are equal, operand A is returned.
- R9: When rec_en is high, cr_we goes high with out_valid. cr_out is then {lt, gt, eq, so_in}: 4'b1000 means A is less than B, 4'b0100 means A is greater, 4'b0010 means equal, and bit 0 carries so_in.
- R10: The condition code describes A relative to B in the selected domain and does not depend on mode bit 2.
- R11: When rec_en is low, cr_we stays low and cr_out keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_a | input | XLEN | First operand |
| a_is_zero_reg | input | 1 | First operand is the zero register; read it as zero |
| op_b | input | XLEN | Second operand |
| mode | input | 3 | [2] maximum, [1] signed, [0] half-width |
| rec_en | input | 1 | Also produce the condition field |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Selected full-width operand |
| cr_out | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we | output | 1 | Condition field written this cycle |

## Verification
Each result, its condition field and the write strobe are due exactly one rising edge after the cycle in which in_valid was high. The driver changes inputs on falling edges and queues an expectation for each operation. The monitor samples 1 ns after every rising edge. Each time it sees out_valid, it pairs that output with the oldest queued expectation. A valid output with nothing queued, or an expectation still queued at the end, counts as a timing failure. The expected condition field is held in the bench across operations that do not record, so that retention is checked cycle-accurately.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

    // Mode field: bit 2 maximum, bit 1 signed, bit 0 half-width.
    typedef struct packed {
        logic take_max;
        logic is_signed;
        logic half_width;
    } mm_mode_t;

    // One-hot relation codes placed above the overflow bit.
    localparam logic [2:0] REL_LT = 3'b100;
    localparam logic [2:0] REL_GT = 3'b010;
    localparam logic [2:0] REL_EQ = 3'b001;

endpackage

// File: rtl/minmax_prep.sv
module minmax_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    input  logic            half_width,
    input  logic            is_signed,
    output logic [XLEN-1:0] prepared
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] shaped;

    always_comb begin
        shaped = val;
        // Lower half moved to the top so that only it decides the compare.
        if (half_width) begin
            shaped = {val[XLEN-HALF-1:0], {HALF{1'b0}}};
        end
        // Flipping the sign bit turns an unsigned compare into a signed one.
        if (is_signed) begin
            shaped[XLEN-1] = ~shaped[XLEN-1];
        end
        prepared = shaped;
    end
endmodule

// File: rtl/minmax_cmp.sv
module minmax_cmp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    output logic            lt,
    output logic            eq
);
    // Borrow out of x - y signals x < y for unsigned operands.
    logic [XLEN:0] diff;

    always_comb begin
        diff = {1'b0, x} - {1'b0, y};
        lt   = diff[XLEN];
        eq   = (x == y);
    end
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] op_a,
    input  logic            a_is_zero_reg,
    input  logic [XLEN-1:0] op_b,
    input  logic [2:0]      mode,
    input  logic            rec_en,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [3:0]      cr_out,
    output logic            cr_we
);
    import minmax_pkg::*;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            we;
        logic [3:0]      cr;
    } mm_state_t;

    mm_state_t st_d, st_q;
    mm_mode_t  md;

    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] prep_a, prep_b;
    logic [XLEN-1:0] cmp_x, cmp_y;
    logic            c_lt, c_eq;
    logic            take_a, rel_lt, rel_gt;
    logic [2:0]      rel_code;

    always_comb begin
        md    = mm_mode_t'(mode);
        src_a = a_is_zero_reg ? '0 : op_a;
    end

    minmax_prep #(.XLEN(XLEN)) u_prep_a (
        .val        (src_a),
        .half_width (md.half_width),
        .is_signed  (md.is_signed),
        .prepared   (prep_a)
    );

    minmax_prep #(.XLEN(XLEN)) u_prep_b (
        .val        (op_b),
        .half_width (md.half_width),
        .is_signed  (md.is_signed),
        .prepared   (prep_b)
    );

    // Maximum mode swaps the inputs so less-than acts as greater-than.
    always_comb begin
        cmp_x = md.take_max ? prep_b : prep_a;
        cmp_y = md.take_max ? prep_a : prep_b;
    end

    minmax_cmp #(.XLEN(XLEN)) u_cmp (
        .x  (cmp_x),
        .y  (cmp_y),
        .lt (c_lt),
        .eq (c_eq)
    );

    always_comb begin
        // Ties return the first operand.
        take_a = c_lt | c_eq;
        // Undo the swap so the relation always describes A against B.
        rel_lt = md.take_max ? (~c_lt & ~c_eq) : c_lt;
        rel_gt = md.take_max ? c_lt : (~c_lt & ~c_eq);
        if (c_eq)        rel_code = REL_EQ;
        else if (rel_lt) rel_code = REL_LT;
        else if (rel_gt) rel_code = REL_GT;
        else             rel_code = REL_EQ;

        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.we  = in_valid & rec_en;
        if (in_valid) begin
            st_d.res = take_a ? src_a : op_b;
            if (rec_en) begin
                st_d.cr = {rel_code, so_in};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cr_out    = st_q.cr;
    assign cr_we     = st_q.we;
endmodule

// File: rtl/minmax_unit_chk.sv
module minmax_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] op_a,
    input logic            a_is_zero_reg,
    input logic [XLEN-1:0] op_b,
    input logic [2:0]      mode,
    input logic            rec_en,
    input logic            so_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic [3:0]      cr_out,
    input logic            cr_we
);
    logic [XLEN-1:0] a_eff;
    logic            mode_seen;
    assign a_eff     = a_is_zero_reg ? '0 : op_a;
    assign mode_seen = ^mode;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    cr_we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cr_we == $past(rec_en)));

    // R9
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_out[3:1]) == 1 && cr_out[0] == $past(so_in)));

    // R11
    cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_we |-> $stable(cr_out));

    // R3
    result_is_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_seen || !mode_seen)) |=> (result == $past(a_eff) || result == $past(op_b)));

    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_is_zero_reg) |=> (result == '0 || result == $past(op_b)));

    // R8
    equal_takes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_eff == op_b) |=> (result == $past(a_eff)));
endmodule

bind minmax_unit minmax_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .op_a          (op_a),
    .a_is_zero_reg (a_is_zero_reg),
    .op_b          (op_b),
    .mode          (mode),
    .rec_en        (rec_en),
    .so_in         (so_in),
    .out_valid     (out_valid),
    .result        (result),
    .cr_out        (cr_out),
    .cr_we         (cr_we)
);

// File: tb/tb_minmax_unit.sv
`timescale 1ns/1ps
module tb_minmax_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] op_a = '0;
    logic            a_is_zero_reg = 1'b0;
    logic [XLEN-1:0] op_b = '0;
    logic [2:0]      mode = '0;
    logic            rec_en = 1'b0;
    logic            so_in = 1'b0;
    logic            out_valid;
    logic [XLEN-1:0] result;
    logic [3:0]      cr_out;
    logic            cr_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [XLEN-1:0] res;
        logic [3:0]      cr;
        logic            we;
        string           tag;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] last_cr = 4'b0000;

    always #2 clk = ~clk;

    minmax_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
        .a_is_zero_reg(a_is_zero_reg), .op_b(op_b), .mode(mode),
        .rec_en(rec_en), .so_in(so_in), .out_valid(out_valid),
        .result(result), .cr_out(cr_out), .cr_we(cr_we)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent reference: 65-bit signed compare of extended values.
    task automatic send(input logic [XLEN-1:0] a, input logic zr, input logic [XLEN-1:0] b,
                        input logic [2:0] md, input logic rec, input logic so, input string tag);
        logic [XLEN-1:0] av;
        logic signed [XLEN:0] ca, cb;
        logic lt, gt, eq, ta;
        exp_t e;
        av = zr ? '0 : a;
        if (md[0]) begin
            ca = md[1] ? {{33{av[31]}}, av[31:0]} : {33'b0, av[31:0]};
            cb = md[1] ? {{33{b[31]}},  b[31:0]}  : {33'b0, b[31:0]};
        end else begin
            ca = md[1] ? {av[63], av} : {1'b0, av};
            cb = md[1] ? {b[63], b}   : {1'b0, b};
        end
        lt = ca < cb;
        gt = ca > cb;
        eq = ca == cb;
        ta = md[2] ? (gt || eq) : (lt || eq);
        if (rec) last_cr = {lt, gt, eq, so};
        e.res = ta ? av : b;
        e.cr  = last_cr;
        e.we  = rec;
        e.tag = tag;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; a_is_zero_reg = zr; op_b = b;
        mode = md; rec_en = rec; so_in = so;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = {XLEN{1'b1}}; op_b = '0; rec_en = 1'b1;
        end
    endtask

    // Monitor: outputs are due one edge after acceptance (R2).
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R2 spurious valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " result"}, result, e.res);
                    check({e.tag, " cr_out R9"}, {60'b0, cr_out}, {60'b0, e.cr});
                    check({e.tag, " cr_we R11"}, {63'b0, cr_we}, {63'b0, e.we});
                end
            end else if (sb.size() != 0) begin
                check("R2 late valid", 64'd0, 64'd1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] x;
        x = 64'h1234_5678_9abc_def1;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 out_valid", {63'b0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        check("R1 cr_out", {60'b0, cr_out}, 64'd0);
        check("R1 cr_we", {63'b0, cr_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {63'b0, out_valid}, 64'd0);

        send(64'd5, 0, 64'd9, 3'b000, 1, 0, "R3 min unsigned");
        send(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 3'b000, 1, 1, "R3 min unsigned big");
        send(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 3'b010, 1, 0, "R5 min signed");
        send(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 3'b100, 1, 1, "R4 R10 max unsigned");
        send(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 3'b110, 1, 0, "R4 R10 max signed");
        idle(2);
        send(64'h0000_0001_0000_0002, 0, 64'h0000_0000_0000_0003, 3'b001, 1, 0, "R6 half min");
        send(64'h0000_0000_8000_0000, 0, 64'hFFFF_FFFF_0000_0001, 3'b011, 1, 0, "R6 half signed min");
        send(64'h0000_0000_8000_0000, 0, 64'hFFFF_FFFF_0000_0001, 3'b101, 1, 1, "R6 half max");
        send(64'd7, 0, 64'd7, 3'b000, 1, 0, "R8 equal min");
        send(64'h0000_0001_0000_0005, 0, 64'h0000_0002_0000_0005, 3'b001, 1, 1, "R8 half equal min");
        send(64'h0000_0001_0000_0005, 0, 64'h0000_0002_0000_0005, 3'b101, 1, 0, "R8 half equal max");
        send(64'd100, 1, 64'd50, 3'b000, 1, 0, "R7 zero reg min");
        send(64'd100, 1, 64'd50, 3'b100, 1, 0, "R7 zero reg max");
        send(64'd1, 0, 64'd2, 3'b000, 0, 1, "R11 no record");
        idle(1);
        send(64'd9, 0, 64'd3, 3'b100, 0, 0, "R11 no record again");
        send(64'd0, 1, 64'd0, 3'b010, 1, 1, "R7 R8 zero equal");
        for (int i = 0; i < 200; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            send(x, x[5] & x[6], {x[31:0], x[63:32]} ^ {32'b0, x[40:9]},
                 x[2:0], x[3], x[4], "R9 sweep");
            if (x[8]) idle(1);
        end
        idle(3);
        check("R2 queue drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule